// File: doc/BRIEF.md
# Reservation Station Issue and Wakeup Scheduler

This block is the dynamic scheduling core of an out-of-order floating-point back end. It keeps a bank of reservation stations (three for addition, two for multiplication, three load buffers) and a per-register table that records which station will produce each architectural register's next value. Instructions arrive in program order. Each source operand is replaced at issue either by its current value or by the tag of the station that will produce it. This renaming lets a later write to the same register issue at once, without waiting for earlier readers or writers.

Stations with both operands present are handed to external fixed-latency execution pipelines. Each class can start one instruction per cycle. Finished results return to their station by tag. A single result bus then broadcasts one finished station per cycle, as value plus source tag. Every waiting station and every register entry compares its pending tag with the bus and picks up the value on a match. The broadcasting station becomes free in the same cycle. A zero tag means "no producer", so operand readiness needs no separate flag.

Top module: `rs_scheduler`

## Requirements
- R1: After reset every station is free, `disp_valid` and `bus_valid` are low, and `iss_ready` is high for classes 0 (add), 1 (multiply) and 2 (load) and low for class 3.
- R2: Station tags are fixed: add stations 1..3, multiply 4..5, load buffers 6..8. An instruction issues to the lowest-numbered free station of its class, and `iss_tag` shows that tag while `iss_ready` is high.
- R3: Issue stalls only when every station of the requested class is busy. Another class still accepts, and a destination register already awaiting a result causes no stall.
- R4: At issue, a source whose register has no pending producer takes the register value. Otherwise it records the producer tag. The destination register's producer becomes the issuing station's tag. Every broadcast result equals the in-order value of its instruction. For loads the second operand is `iss_imm`.
- R5: A station is dispatched only when both pending tags are zero. Dispatch picks the lowest ready station per class, and `disp_*` appear one cycle after the station became ready.
- R6: A waiting station whose pending tag equals the broadcast tag captures the broadcast data and clears that tag.
- R7: At most one broadcast per cycle. Among finished stations the lowest tag wins, and `bus_*` is registered, one cycle after the broadcast decision.
- R8: A result broadcast in the same cycle that a dependent instruction issues is captured by the new station.
- R9: A station is free again after its broadcast and can be reissued, and the lowest free tag is offered again.
- R10: A register takes a broadcast value only if its producer tag matches. After a newer writer has claimed the register, the older result does not overwrite it.
- R11: Add-class operation code 0 is addition and 1 is subtraction (a-b). The code is passed to the unit on `disp_op`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Instruction offered for issue |
| iss_class | input | 2 | 0 add, 1 multiply, 2 load |
| iss_op | input | OP_W | Operation code |
| iss_dst | input | REG_AW | Destination register |
| iss_src1 | input | REG_AW | First source register (load base) |
| iss_src2 | input | REG_AW | Second source register (unused for loads) |
| iss_imm | input | DATA_W | Load offset, used as second operand |
| iss_ready | output | 1 | A station of the requested class is free |
| iss_tag | output | TAG_W | Tag the offered instruction will receive |
| disp_valid | output | 3 | Per-class dispatch strobe |
| disp_tag | output | 3*TAG_W | Per-class dispatched station tag |
| disp_op | output | 3*OP_W | Per-class operation code |
| disp_a | output | 3*DATA_W | Per-class first operand |
| disp_b | output | 3*DATA_W | Per-class second operand |
| res_valid | input | 3 | Per-class result return strobe |
| res_tag | input | 3*TAG_W | Per-class returning station tag |
| res_data | input | 3*DATA_W | Per-class result value |
| bus_valid | output | 1 | Result bus broadcast (registered) |
| bus_tag | output | TAG_W | Producing station tag |
| bus_data | output | DATA_W | Broadcast value |

## Verification
Two functions can meet in one cycle here: the broadcast of a producer and the issue of an instruction that reads that producer's register. The bench waits until the load unit returns a result, then offers a dependent add so that it is accepted exactly in the broadcast cycle. It judges the case by seeing that producer's tag on the registered bus right after acceptance and by the add's own result matching the in-order value. Two stations finishing in the same cycle are also arranged, and the order of their broadcasts is checked.

// File: rtl/rs_sched_pkg.sv
package rs_sched_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EXEC = 2'd2,
    ST_DONE = 2'd3
  } st_state_e;

  localparam int CLS_N = 3;
  localparam int CLS_W = 2;

  function automatic int st_class(input int i, input int add_n, input int mul_n);
    if (i < add_n) return 0;
    else if (i < add_n + mul_n) return 1;
    else return 2;
  endfunction

  function automatic int cls_base(input int c, input int add_n, input int mul_n);
    if (c == 0) return 0;
    else if (c == 1) return add_n;
    else return add_n + mul_n;
  endfunction

  function automatic int cls_cnt(input int c, input int add_n, input int mul_n, input int ld_n);
    if (c == 0) return add_n;
    else if (c == 1) return mul_n;
    else return ld_n;
  endfunction

endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  // fixed priority: lowest index wins
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_station.sv
module rs_station
  import rs_sched_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4,
  parameter int OP_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic [OP_W-1:0]   alloc_op,
  input  logic [TAG_W-1:0]  alloc_qj,
  input  logic [DATA_W-1:0] alloc_vj,
  input  logic [TAG_W-1:0]  alloc_qk,
  input  logic [DATA_W-1:0] alloc_vk,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              dispatch,
  input  logic              res_hit,
  input  logic [DATA_W-1:0] res_data,
  input  logic              bcast,
  output logic              busy,
  output logic              ready,
  output logic              done,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] vj,
  output logic [DATA_W-1:0] vk,
  output logic [DATA_W-1:0] result
);
  st_state_e        state;
  logic [TAG_W-1:0] qj, qk;
  logic             hit_j, hit_k;

  assign hit_j = cdb_valid && (qj != '0) && (qj == cdb_tag);
  assign hit_k = cdb_valid && (qk != '0) && (qk == cdb_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      op     <= '0;
      qj     <= '0;
      qk     <= '0;
      vj     <= '0;
      vk     <= '0;
      result <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (alloc) begin
          state <= ST_WAIT;
          op    <= alloc_op;
          qj    <= alloc_qj;
          vj    <= alloc_vj;
          qk    <= alloc_qk;
          vk    <= alloc_vk;
        end
        ST_WAIT: begin
          if (hit_j) begin
            vj <= cdb_data;
            qj <= '0;
          end
          if (hit_k) begin
            vk <= cdb_data;
            qk <= '0;
          end
          if (dispatch) state <= ST_EXEC;
        end
        ST_EXEC: if (res_hit) begin
          result <= res_data;
          state  <= ST_DONE;
        end
        ST_DONE: if (bcast) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (state != ST_IDLE);
  assign ready = (state == ST_WAIT) && (qj == '0) && (qk == '0);
  assign done  = (state == ST_DONE);

  // R6: a waiting operand picks up the matching broadcast
  a_r6_capture_j: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && hit_j) |=> (qj == '0 && vj == $past(cdb_data)));
  a_r6_capture_k: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && hit_k) |=> (qk == '0 && vk == $past(cdb_data)));
  // R5: dispatch only with both operands present
  a_r5_dispatch_ready: assert property (@(posedge clk) disable iff (rst)
    dispatch |-> (state == ST_WAIT && qj == '0 && qk == '0));
  // R9: broadcast frees the station
  a_r9_free_after_bcast: assert property (@(posedge clk) disable iff (rst)
    (done && bcast) |=> !busy);
  // R2: allocation only into a free station
  a_r2_alloc_free: assert property (@(posedge clk) disable iff (rst)
    alloc |-> !busy);
endmodule

// File: rtl/rs_regstat.sv
module rs_regstat #(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4,
  parameter int REG_N  = 8,
  localparam int REG_AW = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] rd1,
  input  logic [REG_AW-1:0] rd2,
  output logic [DATA_W-1:0] rv1,
  output logic [TAG_W-1:0]  rq1,
  output logic [DATA_W-1:0] rv2,
  output logic [TAG_W-1:0]  rq2,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_reg,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data
);
  logic [DATA_W-1:0] val  [REG_N];
  logic [TAG_W-1:0]  stat [REG_N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < REG_N; r++) begin
        val[r]  <= '0;
        stat[r] <= '0;
      end
    end else begin
      for (int r = 0; r < REG_N; r++) begin
        if (cdb_valid && stat[r] != '0 && stat[r] == cdb_tag) begin
          val[r]  <= cdb_data;
          stat[r] <= '0;
        end
        if (wr_en && wr_reg == REG_AW'(r)) stat[r] <= wr_tag;
      end
    end
  end

  assign rv1 = val[rd1];
  assign rq1 = stat[rd1];
  assign rv2 = val[rd2];
  assign rq2 = stat[rd2];

  for (genvar r = 0; r < REG_N; r++) begin : g_chk
    // R10: matching broadcast retires the producer and writes the value
    a_r10_retire: assert property (@(posedge clk) disable iff (rst)
      (cdb_valid && stat[r] != '0 && stat[r] == cdb_tag && !(wr_en && wr_reg == REG_AW'(r)))
      |=> (stat[r] == '0 && val[r] == $past(cdb_data)));
    // R10: a non-matching broadcast leaves the value alone
    a_r10_keep_newer: assert property (@(posedge clk) disable iff (rst)
      (cdb_valid && stat[r] != cdb_tag) |=> $stable(val[r]));
  end
endmodule

// File: rtl/rs_scheduler.sv
module rs_scheduler
  import rs_sched_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4,
  parameter int OP_W   = 2,
  parameter int REG_N  = 8,
  parameter int ADD_N  = 3,
  parameter int MUL_N  = 2,
  parameter int LD_N   = 3,
  localparam int REG_AW = $clog2(REG_N)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      iss_valid,
  input  logic [1:0]                iss_class,
  input  logic [OP_W-1:0]           iss_op,
  input  logic [REG_AW-1:0]         iss_dst,
  input  logic [REG_AW-1:0]         iss_src1,
  input  logic [REG_AW-1:0]         iss_src2,
  input  logic [DATA_W-1:0]         iss_imm,
  output logic                      iss_ready,
  output logic [TAG_W-1:0]          iss_tag,
  output logic [2:0]                disp_valid,
  output logic [3*TAG_W-1:0]        disp_tag,
  output logic [3*OP_W-1:0]         disp_op,
  output logic [3*DATA_W-1:0]       disp_a,
  output logic [3*DATA_W-1:0]       disp_b,
  input  logic [2:0]                res_valid,
  input  logic [3*TAG_W-1:0]        res_tag,
  input  logic [3*DATA_W-1:0]       res_data,
  output logic                      bus_valid,
  output logic [TAG_W-1:0]          bus_tag,
  output logic [DATA_W-1:0]         bus_data
);
  localparam int ST_N = ADD_N + MUL_N + LD_N;
  localparam int SIW  = (ST_N > 1) ? $clog2(ST_N) : 1;

  logic [ST_N-1:0]   busy, ready, done, alloc, res_hit, disp_gnt, free_gnt, bc_gnt;
  logic [OP_W-1:0]   st_op  [ST_N];
  logic [DATA_W-1:0] st_vj  [ST_N];
  logic [DATA_W-1:0] st_vk  [ST_N];
  logic [DATA_W-1:0] st_res [ST_N];

  logic              free_any [CLS_N];
  logic [TAG_W-1:0]  free_tag [CLS_N];

  logic              iss_fire;
  logic [DATA_W-1:0] rv1, rv2;
  logic [TAG_W-1:0]  rq1, rq2;
  logic [TAG_W-1:0]  opj_q, opk_q;
  logic [DATA_W-1:0] opj_v, opk_v;

  logic              cdb_valid;
  logic [TAG_W-1:0]  cdb_tag;
  logic [DATA_W-1:0] cdb_data;
  logic [SIW-1:0]    bc_idx;

  // ---------------- per-class free and dispatch selection ----------------
  for (genvar c = 0; c < CLS_N; c++) begin : g_cls
    localparam int B  = cls_base(c, ADD_N, MUL_N);
    localparam int N  = cls_cnt(c, ADD_N, MUL_N, LD_N);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]      fg, dg;
    logic [IW-1:0]     f_idx, d_idx;
    logic              f_any, d_any;
    logic              dv_q;
    logic [TAG_W-1:0]  dt_q;
    logic [OP_W-1:0]   do_q;
    logic [DATA_W-1:0] da_q, db_q;

    rs_pick #(.N(N)) u_free (
      .req (~busy[B +: N]),
      .gnt (fg),
      .idx (f_idx),
      .any (f_any)
    );

    rs_pick #(.N(N)) u_disp (
      .req (ready[B +: N]),
      .gnt (dg),
      .idx (d_idx),
      .any (d_any)
    );

    assign free_gnt[B +: N] = fg;
    assign disp_gnt[B +: N] = dg;
    assign free_any[c]      = f_any;
    assign free_tag[c]      = TAG_W'(B) + TAG_W'(f_idx) + TAG_W'(1);

    always_ff @(posedge clk) begin
      if (rst) begin
        dv_q <= 1'b0;
        dt_q <= '0;
        do_q <= '0;
        da_q <= '0;
        db_q <= '0;
      end else begin
        dv_q <= d_any;
        dt_q <= TAG_W'(B) + TAG_W'(d_idx) + TAG_W'(1);
        do_q <= st_op[B + int'(d_idx)];
        da_q <= st_vj[B + int'(d_idx)];
        db_q <= st_vk[B + int'(d_idx)];
      end
    end

    assign disp_valid[c]                  = dv_q;
    assign disp_tag[c*TAG_W +: TAG_W]     = dt_q;
    assign disp_op[c*OP_W +: OP_W]        = do_q;
    assign disp_a[c*DATA_W +: DATA_W]     = da_q;
    assign disp_b[c*DATA_W +: DATA_W]     = db_q;

    // R5: at most one dispatch per class per cycle
    a_r5_one_dispatch: assert property (@(posedge clk) disable iff (rst)
      $onehot0(dg));
  end

  // ---------------- issue side ----------------
  always_comb begin
    iss_ready = 1'b0;
    iss_tag   = '0;
    case (iss_class)
      2'd0: begin iss_ready = free_any[0]; iss_tag = free_tag[0]; end
      2'd1: begin iss_ready = free_any[1]; iss_tag = free_tag[1]; end
      2'd2: begin iss_ready = free_any[2]; iss_tag = free_tag[2]; end
      default: begin iss_ready = 1'b0; iss_tag = '0; end
    endcase
  end

  assign iss_fire = iss_valid && iss_ready;

  rs_regstat #(.DATA_W(DATA_W), .TAG_W(TAG_W), .REG_N(REG_N)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .rd1       (iss_src1),
    .rd2       (iss_src2),
    .rv1       (rv1),
    .rq1       (rq1),
    .rv2       (rv2),
    .rq2       (rq2),
    .wr_en     (iss_fire),
    .wr_reg    (iss_dst),
    .wr_tag    (iss_tag),
    .cdb_valid (cdb_valid),
    .cdb_tag   (cdb_tag),
    .cdb_data  (cdb_data)
  );

  // rename sources, with bypass of the broadcast in flight this cycle
  always_comb begin
    if (rq1 == '0) begin
      opj_q = '0;  opj_v = rv1;
    end else if (cdb_valid && rq1 == cdb_tag) begin
      opj_q = '0;  opj_v = cdb_data;
    end else begin
      opj_q = rq1; opj_v = '0;
    end
    if (iss_class == 2'd2) begin
      opk_q = '0;  opk_v = iss_imm;
    end else if (rq2 == '0) begin
      opk_q = '0;  opk_v = rv2;
    end else if (cdb_valid && rq2 == cdb_tag) begin
      opk_q = '0;  opk_v = cdb_data;
    end else begin
      opk_q = rq2; opk_v = '0;
    end
  end

  // ---------------- station bank ----------------
  for (genvar i = 0; i < ST_N; i++) begin : g_st
    localparam int C = st_class(i, ADD_N, MUL_N);

    assign alloc[i]   = iss_fire && (iss_class == CLS_W'(C)) && free_gnt[i];
    assign res_hit[i] = res_valid[C] && (res_tag[C*TAG_W +: TAG_W] == TAG_W'(i + 1));

    rs_station #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) u_st (
      .clk       (clk),
      .rst       (rst),
      .alloc     (alloc[i]),
      .alloc_op  (iss_op),
      .alloc_qj  (opj_q),
      .alloc_vj  (opj_v),
      .alloc_qk  (opk_q),
      .alloc_vk  (opk_v),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .cdb_data  (cdb_data),
      .dispatch  (disp_gnt[i]),
      .res_hit   (res_hit[i]),
      .res_data  (res_data[C*DATA_W +: DATA_W]),
      .bcast     (bc_gnt[i]),
      .busy      (busy[i]),
      .ready     (ready[i]),
      .done      (done[i]),
      .op        (st_op[i]),
      .vj        (st_vj[i]),
      .vk        (st_vk[i]),
      .result    (st_res[i])
    );
  end

  // ---------------- result bus ----------------
  rs_pick #(.N(ST_N)) u_bcast (
    .req (done),
    .gnt (bc_gnt),
    .idx (bc_idx),
    .any (cdb_valid)
  );

  assign cdb_tag  = TAG_W'(bc_idx) + TAG_W'(1);
  assign cdb_data = st_res[bc_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid <= 1'b0;
      bus_tag   <= '0;
      bus_data  <= '0;
    end else begin
      bus_valid <= cdb_valid;
      bus_tag   <= cdb_valid ? cdb_tag : '0;
      bus_data  <= cdb_data;
    end
  end

  // R7: a single broadcast per cycle, never tag zero
  a_r7_one_bcast: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bc_gnt));
  a_r7_bus_tag_nonzero: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> (bus_tag != '0));
  // R2: an offered tag is never the empty marker
  a_r2_tag_nonzero: assert property (@(posedge clk) disable iff (rst)
    iss_ready |-> (iss_tag != '0));
  // R8: an issuing source that matches the broadcast is not left waiting
  a_r8_issue_bypass: assert property (@(posedge clk) disable iff (rst)
    (iss_fire && cdb_valid && rq1 == cdb_tag) |-> (opj_q == '0));
endmodule

// File: tb/rs_scheduler_tb.sv
module rs_scheduler_tb;
  localparam int DW = 64;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          iss_valid;
  logic [1:0]    iss_class;
  logic [1:0]    iss_op;
  logic [2:0]    iss_dst, iss_src1, iss_src2;
  logic [DW-1:0] iss_imm;
  logic          iss_ready;
  logic [TW-1:0] iss_tag;
  logic [2:0]    disp_valid;
  logic [3*TW-1:0] disp_tag;
  logic [5:0]      disp_op;
  logic [3*DW-1:0] disp_a, disp_b;
  logic [2:0]      res_valid;
  logic [3*TW-1:0] res_tag;
  logic [3*DW-1:0] res_data;
  logic          bus_valid;
  logic [TW-1:0] bus_tag;
  logic [DW-1:0] bus_data;

  rs_scheduler u_dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_class(iss_class), .iss_op(iss_op),
    .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_imm(iss_imm),
    .iss_ready(iss_ready), .iss_tag(iss_tag), .disp_valid(disp_valid), .disp_tag(disp_tag),
    .disp_op(disp_op), .disp_a(disp_a), .disp_b(disp_b), .res_valid(res_valid),
    .res_tag(res_tag), .res_data(res_data), .bus_valid(bus_valid), .bus_tag(bus_tag),
    .bus_data(bus_data)
  );

  initial forever #4 clk = ~clk;   // 125 MHz

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct { logic [TW-1:0] tag; logic [DW-1:0] val; int rq; } exp_t;
  exp_t expq[$];
  logic [DW-1:0] ref_rf [8];
  logic [TW-1:0] bus_log [$];
  int            bus_cyc [$];
  int            cyc = 0;

  function automatic string rq_name(input int rq);
    case (rq)
      4: return "R4";
      6: return "R6";
      8: return "R8";
      10: return "R10";
      11: return "R11";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [DW-1:0] mem_f(input logic [DW-1:0] a);
    return (a * 64'h9E3779B97F4A7C15) ^ 64'h1234;
  endfunction

  function automatic logic [DW-1:0] unit_f(input int c, input logic [1:0] op,
                                           input logic [DW-1:0] a, input logic [DW-1:0] b);
    if (c == 0) return op[0] ? (a - b) : (a + b);
    else if (c == 1) return a * b;
    else return mem_f(a + b);
  endfunction

  function automatic int lat_f(input int c);
    return (c == 0) ? 2 : ((c == 1) ? 4 : 3);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // ---------------- execution unit models (fixed latency) ----------------
  logic          ex_v   [3][8];
  int            ex_cnt [3][8];
  logic [TW-1:0] ex_tag [3][8];
  logic [DW-1:0] ex_dat [3][8];

  initial begin
    res_valid = '0; res_tag = '0; res_data = '0;
    for (int c = 0; c < 3; c++)
      for (int s = 0; s < 8; s++) begin
        ex_v[c][s] = 1'b0; ex_cnt[c][s] = 0; ex_tag[c][s] = '0; ex_dat[c][s] = '0;
      end
    forever begin
      @(negedge clk);
      cyc++;
      res_valid = '0;
      for (int c = 0; c < 3; c++) begin
        for (int s = 0; s < 8; s++) begin
          if (ex_v[c][s]) begin
            ex_cnt[c][s]--;
            if (ex_cnt[c][s] == 0) begin
              res_valid[c] = 1'b1;
              res_tag[c*TW +: TW]  = ex_tag[c][s];
              res_data[c*DW +: DW] = ex_dat[c][s];
              ex_v[c][s] = 1'b0;
            end
          end
        end
        if (!rst && disp_valid[c]) begin
          for (int s = 0; s < 8; s++) begin
            if (!ex_v[c][s]) begin
              ex_v[c][s]   = 1'b1;
              ex_cnt[c][s] = lat_f(c);
              ex_tag[c][s] = disp_tag[c*TW +: TW];
              ex_dat[c][s] = unit_f(c, disp_op[c*2 +: 2], disp_a[c*DW +: DW], disp_b[c*DW +: DW]);
              break;
            end
          end
        end
      end
    end
  end

  // ---------------- monitor: pop and compare broadcasts ----------------
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && bus_valid) begin
        int found;
        found = -1;
        bus_log.push_back(bus_tag);
        bus_cyc.push_back(cyc);
        for (int i = 0; i < expq.size(); i++)
          if (found < 0 && expq[i].tag == bus_tag) found = i;
        if (found < 0) begin
          chk(1'b0, "R4 unexpected tag", {60'd0, bus_tag}, 64'd0);
        end else begin
          chk(bus_data == expq[found].val, rq_name(expq[found].rq), bus_data, expq[found].val);
          expq.delete(found);
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic issue(input int cls, input logic [1:0] op, input int dst, input int s1,
                       input int s2, input logic [DW-1:0] imm, input int rq,
                       output logic [TW-1:0] tag);
    exp_t e;
    logic [DW-1:0] a, b;
    iss_class = 2'(cls); iss_op = op; iss_dst = 3'(dst);
    iss_src1 = 3'(s1); iss_src2 = 3'(s2); iss_imm = imm; iss_valid = 1'b1;
    forever begin
      #1;
      if (iss_ready) break;
      @(negedge clk);
    end
    tag = iss_tag;
    a = ref_rf[s1];
    b = (cls == 2) ? imm : ref_rf[s2];
    e.tag = tag; e.val = unit_f(cls, op, a, b); e.rq = rq;
    expq.push_back(e);
    ref_rf[dst] = e.val;
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R4 actual=hung expected=drained");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] t;
    logic [15:0]   lf;
    int            k;
    for (int r = 0; r < 8; r++) ref_rf[r] = '0;
    rst = 1'b1; iss_valid = 1'b0; iss_class = '0; iss_op = '0;
    iss_dst = '0; iss_src1 = '0; iss_src2 = '0; iss_imm = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: idle state after reset
    chk(bus_valid == 1'b0, "R1 bus", {63'd0, bus_valid}, 64'd0);
    chk(disp_valid == 3'b000, "R1 dispatch", {61'd0, disp_valid}, 64'd0);
    for (int c = 0; c < 4; c++) begin
      iss_class = 2'(c); #1;
      chk(iss_ready == (c < 3), "R1 ready", {63'd0, iss_ready}, {63'd0, (c < 3)});
      // R2: lowest tag of each class offered
      if (c < 3)
        chk(iss_tag == ((c == 0) ? 4'd1 : ((c == 1) ? 4'd4 : 4'd6)), "R2 first tag",
            {60'd0, iss_tag}, (c == 0) ? 64'd1 : ((c == 1) ? 64'd4 : 64'd6));
    end
    @(negedge clk);

    // seed registers through loads (R4)
    issue(2, 2'd0, 1, 0, 0, 64'd10, 4, t);
    issue(2, 2'd0, 2, 0, 0, 64'd20, 4, t);
    issue(2, 2'd0, 3, 0, 0, 64'd30, 4, t);
    drain();

    // R6 dependent chain, R11 subtraction
    issue(0, 2'd0, 5, 1, 2, 64'd0, 6, t);
    issue(1, 2'd0, 6, 5, 3, 64'd0, 6, t);
    issue(0, 2'd1, 7, 6, 1, 64'd0, 11, t);
    drain();

    // R3 / R2 / R5: fill add class behind a pending load
    issue(2, 2'd0, 4, 1, 0, 64'd5, 4, t);
    issue(0, 2'd0, 5, 4, 4, 64'd0, 6, t);
    chk(t == 4'd1, "R2 add tag", {60'd0, t}, 64'd1);
    issue(0, 2'd0, 6, 4, 1, 64'd0, 6, t);
    chk(t == 4'd2, "R2 add tag", {60'd0, t}, 64'd2);
    issue(0, 2'd1, 7, 4, 2, 64'd0, 11, t);
    chk(t == 4'd3, "R2 add tag", {60'd0, t}, 64'd3);
    iss_class = 2'd0; #1;
    chk(iss_ready == 1'b0, "R3 full add class", {63'd0, iss_ready}, 64'd0);
    chk(disp_valid[0] == 1'b0, "R5 no early dispatch", {63'd0, disp_valid[0]}, 64'd0);
    iss_class = 2'd1; #1;
    chk(iss_ready == 1'b1, "R3 other class free", {63'd0, iss_ready}, 64'd1);
    @(negedge clk);
    // R3: WAW on r5 with its add still waiting; must be accepted at once
    k = cyc;
    issue(1, 2'd0, 5, 1, 2, 64'd0, 4, t);
    chk(cyc - k == 1, "R3 no WAW stall", 64'(cyc - k), 64'd1);
    drain();
    // R9: stations free again
    iss_class = 2'd0; #1;
    chk(iss_ready && iss_tag == 4'd1, "R9 reuse", {60'd0, iss_tag}, 64'd1);
    @(negedge clk);

    // R10: older mul result must not overwrite younger add result in r6
    issue(1, 2'd0, 6, 1, 2, 64'd0, 4, t);
    issue(0, 2'd0, 6, 2, 3, 64'd0, 4, t);
    drain();
    issue(0, 2'd0, 7, 6, 0, 64'd0, 10, t);
    drain();

    // R8: dependent issue in the same cycle as producer broadcast
    issue(2, 2'd0, 2, 0, 0, 64'd77, 4, t);
    chk(t == 4'd6, "R8 load tag", {60'd0, t}, 64'd6);
    forever begin
      #2;
      if (res_valid[2]) break;
      @(negedge clk);
    end
    @(negedge clk);
    issue(0, 2'd0, 3, 2, 2, 64'd0, 8, t);
    chk(bus_valid && bus_tag == 4'd6, "R8 coincident broadcast", {60'd0, bus_tag}, 64'd6);
    drain();

    // R7: add and mul finish together; lower tag broadcasts first
    k = bus_log.size();
    issue(1, 2'd0, 4, 1, 3, 64'd0, 4, t);
    @(negedge clk);
    issue(0, 2'd0, 5, 1, 3, 64'd0, 4, t);
    drain();
    chk(bus_log.size() == k + 2, "R7 count", 64'(bus_log.size() - k), 64'd2);
    if (bus_log.size() == k + 2) begin
      chk(bus_log[k] == 4'd1, "R7 priority first", {60'd0, bus_log[k]}, 64'd1);
      chk(bus_log[k+1] == 4'd4, "R7 priority second", {60'd0, bus_log[k+1]}, 64'd4);
      chk(bus_cyc[k+1] == bus_cyc[k] + 1, "R7 one per cycle",
          64'(bus_cyc[k+1] - bus_cyc[k]), 64'd1);
    end

    // R4: pseudo-random back-to-back stream
    lf = 16'hACE1;
    for (int n = 0; n < 80; n++) begin
      int cls;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cls = int'(lf[1:0]) % 3;
      issue(cls, {1'b0, lf[2]}, 1 + int'(lf[5:3]) % 7, int'(lf[8:6]), int'(lf[11:9]),
            {48'd0, lf}, 4, t);
    end
    drain();
    // R4: read every register back through an add of r0
    for (int r = 1; r < 8; r++) issue(0, 2'd0, r, r, 0, 64'd0, 4, t);
    drain();
    chk(expq.size() == 0, "R9 all retired", 64'(expq.size()), 64'd0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule